// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction per clock cycle. It handles a nine-instruction subset: two memory transfers (load word, store word), five register-to-register operations (add, sub, and, or, set-less-than), a conditional branch on equality and an absolute jump. Every instruction, including a load, completes within the single long cycle in which it is fetched.

The core drives two separate memory ports. The instruction port and the data port both read combinationally from the address the core presents. The data port writes on the rising clock edge while the write strobe is high. Inside the core are a 32-entry register file, one ALU, the immediate sign extender, and the main and ALU-operation decoders. For debug, the core brings out the current PC and a copy of each register-file write as it commits.

Reset is an active-low asynchronous input. The core starts executing once a short internal synchronizer has released it. Until then the PC holds zero and no stores or register writes take place.

Top module: `sc_subset_core`

## Requirements
- R1: While reset is active, and until the internal release completes, the PC output reads 0, the data write strobe is low and the debug write valid is low. The first instruction executed is the one at address 0.
- R2: An instruction that is not a taken branch and not a jump sets the next PC to the current PC plus 4.
- R3: Opcode 000000 selects a register operation that writes its result to the rd field (bits 15:11). The sources are rs (bits 25:21) and rt (bits 20:16). The funct field (bits 5:0) selects the operation: 100000 add, 100010 sub (rs minus rt), 100100 and, 100101 or.
- R4: Funct 101010 (set-less-than) writes 1 to rd when rs is less than rt as signed two's complement values, and writes 0 otherwise.
- R5: Opcode 100011 (load word) reads the data port at rs plus the sign-extended bits 15:0 and writes the read value to rt.
- R6: Opcode 101011 (store word) presents rs plus the sign-extended bits 15:0 on the data address and the value of rt on the write data, with the write strobe high for that one cycle. It writes no register.
- R7: Opcode 000100 (branch-if-equal) sets the next PC to PC+4 plus the sign-extended bits 15:0 shifted left by 2 when rs equals rt, and to PC+4 otherwise. A negative offset branches backward.
- R8: Opcode 000010 (jump) sets the next PC to the upper 4 bits of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R9: Register 0 always reads as zero. A write aimed at it is discarded and does not show on the debug write port.
- R10: For each committed register write, the debug port gives a valid strobe, the destination index and the written value during the cycle in which the instruction executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled on the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr |
| dbg_pc | output | 32 | Current PC |
| dbg_wr_en | output | 1 | A register write commits this cycle |
| dbg_wr_idx | output | 5 | Destination register of the write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
Every instruction retires in the cycle it is fetched. A wrong decode or a wrong ALU result therefore shows up on the debug write port or on the store port in that same cycle. A wrong next-PC value shows up on the PC output one edge later as a skipped or repeated address. Corrupted register contents stay hidden until a later instruction reads them. The bench therefore chains results: a value is loaded, used by an ALU operation, and then stored or compared in a branch, so that a bad register shows within a few instructions. The PC trace, once repeated addresses are merged, is compared against the expected visit order. This catches a branch taken the wrong way or a jump to the wrong target at the first instruction fetched after it.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN    = 32;
  localparam int RIDX_W  = 5;
  localparam int NREGS   = 1 << RIDX_W;
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_sel_e;

  typedef struct packed {
    logic     reg_write;
    logic     dst_is_rd;
    logic     use_imm;
    logic     from_mem;
    logic     mem_write;
    logic     branch;
    logic     jump;
    alu_sel_e alu;
  } ctrl_t;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu = ALU_ADD;
    unique case (opcode)
      OP_REG: begin
        ctrl.dst_is_rd = 1'b1;
        unique case (funct)
          FN_ADD: begin ctrl.reg_write = 1'b1; ctrl.alu = ALU_ADD; end
          FN_SUB: begin ctrl.reg_write = 1'b1; ctrl.alu = ALU_SUB; end
          FN_AND: begin ctrl.reg_write = 1'b1; ctrl.alu = ALU_AND; end
          FN_OR:  begin ctrl.reg_write = 1'b1; ctrl.alu = ALU_OR;  end
          FN_SLT: begin ctrl.reg_write = 1'b1; ctrl.alu = ALU_SLT; end
          default: ctrl.reg_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.from_mem  = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ:  ctrl.branch = 1'b1;
      OP_JUMP: ctrl.jump   = 1'b1;
      default: ctrl = '0;
    endcase
  end

  // R6: a store never also writes a register, branches or jumps
  always_comb begin
    assert_ctrl_exclusive_R6: assert ($onehot0({ctrl.mem_write, ctrl.reg_write, ctrl.branch, ctrl.jump}))
      else $error("decode raised more than one side effect");
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rb_idx,
  output logic [XLEN-1:0]   ra_data,
  output logic [XLEN-1:0]   rb_data,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_data
);
  logic [XLEN-1:0] regs_q [NREGS];
  logic            wr_live;

  assign wr_live = wr_en && (wr_idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_live) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    ra_data = (ra_idx == '0) ? '0 : regs_q[ra_idx];
    rb_data = (rb_idx == '0) ? '0 : regs_q[rb_idx];
  end

  // R9: entry zero is never loaded
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> regs_q[0] == '0);
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
(
  input  alu_sel_e        sel,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic [XLEN-1:0] diff;
  logic            lt_signed;

  assign diff = a - b;
  // signed less-than from the sign bits and the difference
  assign lt_signed = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

  always_comb begin
    unique case (sel)
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt_signed};
      default: y = '0;
    endcase
  end

  // R4: set-less-than yields only 0 or 1, agreeing with a signed compare
  always_comb begin
    if (sel == ALU_SLT) begin
      assert_slt_range_R4: assert (y[XLEN-1:1] == '0 && y[0] == ($signed(a) < $signed(b)))
        else $error("slt result out of range");
    end
  end
endmodule

// File: rtl/sc_subset_core.sv
module sc_subset_core
  import sc_core_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic [31:0] dbg_pc,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_idx,
  output logic [31:0] dbg_wr_data
);
  logic              run;
  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_d;
  logic              pc_en;
  logic [XLEN-1:0]   pc_plus4;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   br_target;
  logic [XLEN-1:0]   jmp_target;
  logic [5:0]        f_op;
  logic [5:0]        f_fn;
  logic [RIDX_W-1:0] f_rs;
  logic [RIDX_W-1:0] f_rt;
  logic [RIDX_W-1:0] f_rd;
  logic [IMM_W-1:0]  f_imm;
  logic [JIDX_W-1:0] f_jidx;
  ctrl_t             ctrl;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic [XLEN-1:0]   wb_data;
  logic [RIDX_W-1:0] wb_idx;
  logic              wb_en;
  logic              br_taken;
  logic              unused_shamt;

  sc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  // instruction fields
  assign f_op   = imem_rdata[31:26];
  assign f_rs   = imem_rdata[25:21];
  assign f_rt   = imem_rdata[20:16];
  assign f_rd   = imem_rdata[15:11];
  assign f_fn   = imem_rdata[5:0];
  assign f_imm  = imem_rdata[15:0];
  assign f_jidx = imem_rdata[25:0];
  assign unused_shamt = ^imem_rdata[10:6];

  sc_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  sc_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (f_rs),
    .rb_idx  (f_rt),
    .ra_data (rs_val),
    .rb_data (rt_val),
    .wr_en   (wb_en),
    .wr_idx  (wb_idx),
    .wr_data (wb_data)
  );

  assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu u_alu (
    .sel (ctrl.alu),
    .a   (rs_val),
    .b   (alu_b),
    .y   (alu_y)
  );

  // write-back path
  assign wb_data = ctrl.from_mem ? dmem_rdata : alu_y;
  assign wb_idx  = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wb_en   = run && ctrl.reg_write;

  // next-PC selection
  assign pc_plus4   = pc_q + XLEN'(4);
  assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], f_jidx, 2'b00};
  assign br_taken   = ctrl.branch && (rs_val == rt_val);
  assign pc_en      = run;

  always_comb begin
    pc_d = pc_plus4;
    if (ctrl.jump)    pc_d = jmp_target;
    else if (br_taken) pc_d = br_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // ports
  assign imem_addr   = pc_q;
  assign dbg_pc      = pc_q;
  assign dmem_addr   = alu_y;
  assign dmem_wdata  = rt_val;
  assign dmem_we     = run && ctrl.mem_write;
  assign dbg_wr_en   = wb_en && (wb_idx != '0);
  assign dbg_wr_idx  = wb_idx;
  assign dbg_wr_data = wb_data;

  // R1: nothing is written while the core is held idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!dmem_we && !dbg_wr_en && pc_q == '0));

  // R2: sequential flow advances by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctrl.jump && !(ctrl.branch && rs_val == rt_val)) |=> pc_q == $past(pc_q) + 32'd4);

  // R7: equal operands on a branch redirect the fetch
  assert_branch_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl.branch && rs_val == rt_val) |=> pc_q == $past(pc_q) + 32'd4 + {$past(imm_ext[29:0]), 2'b00});

  // R8: jump keeps the upper PC nibble and takes the index
  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl.jump) |=> pc_q[27:0] == {$past(imem_rdata[25:0]), 2'b00});

  // R9: register zero never shows on the debug write port
  assert_no_zero_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_en |-> dbg_wr_idx != '0);

  // R6: a store cycle commits no register write
  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !dbg_wr_en);
endmodule

// File: tb/tb_sc_subset_core.sv
module tb_sc_subset_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_idx;
  logic [31:0] dbg_wr_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  // logs taken from the ports
  logic        logging = 1'b0;
  int          n_pc = 0, n_wr = 0, n_st = 0;
  logic [31:0] pc_log [64];
  logic [4:0]  wr_idx_log [64];
  logic [31:0] wr_dat_log [64];
  logic [31:0] st_adr_log [16];
  logic [31:0] st_dat_log [16];

  always #4 clk = ~clk;  // 125 MHz

  sc_subset_core dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata),
    .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en), .dbg_wr_idx(dbg_wr_idx),
    .dbg_wr_data(dbg_wr_data)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  always @(negedge clk) begin
    if (logging) begin
      if ((n_pc == 0 || pc_log[n_pc-1] != dbg_pc) && n_pc < 64) begin
        pc_log[n_pc] = dbg_pc;
        n_pc++;
      end
      if (dbg_wr_en && n_wr < 64) begin
        wr_idx_log[n_wr] = dbg_wr_idx;
        wr_dat_log[n_wr] = dbg_wr_data;
        n_wr++;
      end
      if (dmem_we && n_st < 16) begin
        st_adr_log[n_st] = dmem_addr;
        st_dat_log[n_st] = dmem_wdata;
        n_st++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic load_program();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    dmem[0] = 32'd6;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[2] = 32'hDEAD_BEEF;
    dmem[3] = 32'h0;
    imem[0]  = enc_i(6'b100011, 0, 1, 16'd0);    // lw r1,0(r0)
    imem[1]  = enc_i(6'b100011, 0, 2, 16'd4);    // lw r2,4(r0)
    imem[2]  = enc_r(1, 2, 3, 6'b100000);        // add r3
    imem[3]  = enc_r(1, 2, 4, 6'b100010);        // sub r4
    imem[4]  = enc_r(1, 2, 5, 6'b100100);        // and r5
    imem[5]  = enc_r(1, 2, 6, 6'b100101);        // or  r6
    imem[6]  = enc_r(2, 1, 7, 6'b101010);        // slt r7 = (-3 < 6)
    imem[7]  = enc_r(1, 2, 8, 6'b101010);        // slt r8 = (6 < -3)
    imem[8]  = enc_r(1, 1, 0, 6'b100000);        // add r0 (discarded)
    imem[9]  = enc_i(6'b101011, 0, 0, 16'd8);    // sw r0,8(r0)
    imem[10] = enc_i(6'b101011, 0, 4, 16'd12);   // sw r4,12(r0)
    imem[11] = enc_i(6'b000100, 1, 2, 16'd5);    // beq r1,r2 not taken
    imem[12] = enc_i(6'b000100, 1, 1, 16'd2);    // beq r1,r1 -> 60
    imem[13] = enc_r(1, 1, 9, 6'b100000);        // skipped
    imem[14] = enc_r(1, 1, 9, 6'b100000);        // skipped
    imem[15] = {6'b000010, 26'd20};              // j 80
    imem[16] = enc_r(1, 1, 10, 6'b100000);       // skipped
    imem[20] = enc_i(6'b000100, 0, 0, 16'hFFFF); // beq r0,r0,-1 -> 80
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pc in reset", dbg_pc, 32'h0);
    check("R1 store strobe in reset", {31'h0, dmem_we}, 32'h0);
    check("R1 debug write in reset", {31'h0, dbg_wr_en}, 32'h0);
    logging = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pc held during release", dbg_pc, 32'h0);
    repeat (40) @(negedge clk);
    logging = 1'b0;
  endtask

  task automatic t_loads();
    check("R5 lw r1 idx", {27'h0, wr_idx_log[0]}, 32'd1);
    check("R5 lw r1 data", wr_dat_log[0], 32'd6);
    check("R5 lw r2 idx", {27'h0, wr_idx_log[1]}, 32'd2);
    check("R5 lw r2 data", wr_dat_log[1], 32'hFFFF_FFFD);
  endtask

  task automatic t_alu();
    check("R3 add", wr_dat_log[2], 32'd3);
    check("R3 add rd idx", {27'h0, wr_idx_log[2]}, 32'd3);
    check("R3 sub", wr_dat_log[3], 32'd9);
    check("R3 and", wr_dat_log[4], 32'd4);
    check("R3 or", wr_dat_log[5], 32'hFFFF_FFFF);
    check("R4 slt neg<pos", wr_dat_log[6], 32'd1);
    check("R4 slt pos<neg signed", wr_dat_log[7], 32'd0);
    check("R10 r8 idx", {27'h0, wr_idx_log[7]}, 32'd8);
  endtask

  task automatic t_zero_reg();
    int zero_seen = 0;
    for (int i = 0; i < n_wr; i++) if (wr_idx_log[i] == 5'd0) zero_seen++;
    check("R9 no debug write to r0", zero_seen, 0);
    check("R10 total committed writes", n_wr, 8);
  endtask

  task automatic t_stores();
    check("R6 store count", n_st, 2);
    check("R6 sw r0 address", st_adr_log[0], 32'd8);
    check("R9 sw r0 data reads zero", st_dat_log[0], 32'h0);
    check("R6 sw r4 address", st_adr_log[1], 32'd12);
    check("R6 sw r4 data", st_dat_log[1], 32'd9);
    check("R6 memory word 2", dmem[2], 32'h0);
    check("R6 memory word 3", dmem[3], 32'd9);
  endtask

  task automatic t_flow();
    logic [31:0] exp_pc [14];
    for (int i = 0; i < 13; i++) exp_pc[i] = 32'(i * 4);
    exp_pc[12] = 32'd48;
    exp_pc[13] = 32'd60;
    check("R2 pc trace length", n_pc, 15);
    for (int i = 0; i < 12; i++) check("R2 sequential pc", pc_log[i], exp_pc[i]);
    check("R7 untaken beq falls through", pc_log[12], 32'd48);
    check("R7 taken beq target", pc_log[13], 32'd60);
    check("R8 jump target", pc_log[14], 32'd80);
    check("R7 backward beq holds at 80", dbg_pc, 32'd80);
  endtask

  initial begin
    load_program();
    t_reset();
    t_loads();
    t_alu();
    t_zero_reg();
    t_stores();
    t_flow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule